// File: doc/BRIEF.md
# Floating-Point Exception Status and Mask Register

This block holds the control word and the status word of a stack-organised floating-point unit. Every cycle the arithmetic datapath presents a vector of six exception conditions and a stack-fault strobe. The block folds them into sticky flags. It compares the flags against six mask bits kept in the control word. When any flag is set and its mask bit is clear, the block raises an interrupt request. A masked condition only leaves its flag set, and the datapath supplies a default result.

Software-style ports allow reading both words, writing the control word and the flag part of the status word, and issuing two commands. One command initialises the whole block. The other clears the exceptions. Neighbouring logic supplies the stack-top pointer and the four condition bits, and the block merges them into the status word it returns.

Top module: `fpx_status_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `cw_rd` is 0x037F (all six masks set), `sw_rd` is 0x0000 and `irq` is 0.
- R2: Flag bits sit in `sw_rd[5:0]` as precision 5, underflow 4, overflow 3, zero-divide 2, denormal 1, invalid 0. The mask bits sit in `cw_rd[5:0]` in the same order. A bit raised on `dp_flags` appears in `sw_rd` after one clock edge.
- R3: Flags are sticky. Without a command or a status write, a set flag stays set whatever `dp_flags` carries.
- R4: `cmd_clex` clears all six flags and the stack-fault bit, but conditions raised on `dp_flags` or `dp_stk_fault` in the same cycle are still captured. In that cycle `cmd_clex` also overrides `sw_wr`.
- R5: `cmd_init` returns `cw_rd` to 0x037F and `sw_rd[7:0]` to 0. It overrides `cmd_clex`, `cw_wr`, `sw_wr` and any datapath raise in the same cycle.
- R6: `dp_stk_fault` sets the stack-fault bit `sw_rd[6]` and the invalid flag `sw_rd[0]`.
- R7: `irq` and `sw_rd[7]` are both 1 exactly when some `sw_rd[i]` (i in 0..5) is 1 while `cw_rd[i]` is 0. Masked flags raise no request.
- R8: A control-word write shows in `cw_rd` after one edge. If that write unmasks a flag that is already set, `irq` rises on the same edge.
- R9: `sw_wr` loads `sw_wdata[5:0]` into the flags and `sw_wdata[6]` into the stack-fault bit. Conditions raised in the same cycle are ORed into the loaded value.
- R10: After one edge, `sw_rd[13:11]` holds `top_ptr`, `sw_rd[14]` holds `cond[3]` and `sw_rd[10:8]` holds `cond[2:0]`. `sw_rd[15]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dp_flags | input | 6 | Exception conditions raised this cycle |
| dp_stk_fault | input | 1 | Stack over- or underflow raised this cycle |
| top_ptr | input | 3 | Stack-top pointer from the register-stack logic |
| cond | input | 4 | Condition bits from the compare logic |
| cw_wr | input | 1 | Control-word write strobe |
| cw_wdata | input | 16 | Control-word write data |
| sw_wr | input | 1 | Status-flag write strobe |
| sw_wdata | input | 7 | Stack-fault bit (6) and flags (5:0) to load |
| cmd_init | input | 1 | Initialise both words |
| cmd_clex | input | 1 | Clear exception flags and stack fault |
| cw_rd | output | 16 | Control word |
| sw_rd | output | 16 | Status word |
| irq | output | 1 | Unmasked-exception request |

## Verification
The overlaps that matter are a clear or a status write landing in the same cycle as a fresh datapath raise, and an unmask landing on a flag that is already set. Table rows drive `cmd_clex` together with a masked or an unmasked `dp_flags` bit. The bench then checks that the new bit survives and that the old bits are gone. Other rows pair `sw_wr` with a raise, which must OR into the loaded value. A control-word write that clears a mask bit is issued over a flag that is already set, and `irq` must rise on the same edge as the new `cw_rd`. One row asserts every command and raise at once, and initialise must win.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLAG   = 6;
  localparam int WORD_W  = 16;
  localparam int TOP_W   = 3;
  localparam int COND_W  = 4;
  localparam int SF_BIT  = NFLAG;
  localparam int IRQ_BIT = NFLAG + 1;
  localparam int SWD_W   = NFLAG + 1;
  localparam logic [WORD_W-1:0] CW_INIT = 16'h037F;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_INIT  = 2'd3
  } flag_act_e;
endpackage

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank
  import fpx_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic             clk,
  input  logic             rst,
  input  flag_act_e        act,
  input  logic [N-1:0]     ld_flags,
  input  logic             ld_sf,
  input  logic [N-1:0]     raise,
  input  logic             stk_fault,
  output logic [N-1:0]     flags_nx,
  output logic             sf_nx
);
  logic [N-1:0] flags_q;
  logic         sf_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic hit;
    logic base;
    if (i == 0) begin : g_inv
      assign hit = raise[i] | stk_fault;
    end else begin : g_oth
      assign hit = raise[i];
    end
    always_comb begin
      case (act)
        ACT_LOAD:  base = ld_flags[i];
        ACT_CLEAR: base = 1'b0;
        ACT_INIT:  base = 1'b0;
        default:   base = flags_q[i];
      endcase
      flags_nx[i] = (act == ACT_INIT) ? 1'b0 : (base | hit);
    end
  end

  always_comb begin
    case (act)
      ACT_LOAD:  sf_nx = ld_sf | stk_fault;
      ACT_CLEAR: sf_nx = stk_fault;
      ACT_INIT:  sf_nx = 1'b0;
      default:   sf_nx = sf_q | stk_fault;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      sf_q    <= 1'b0;
    end else begin
      flags_q <= flags_nx;
      sf_q    <= sf_nx;
    end
  end
endmodule

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
  import fpx_pkg::*;
#(
  parameter int W = WORD_W,
  parameter logic [W-1:0] INIT_VAL = CW_INIT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cw_nx,
  output logic [W-1:0] cw_q
);
  always_comb begin
    if (init)    cw_nx = INIT_VAL;
    else if (wr) cw_nx = wdata;
    else         cw_nx = cw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cw_q <= INIT_VAL;
    else     cw_q <= cw_nx;
  end
endmodule

// File: rtl/fpx_irq_gen.sv
module fpx_irq_gen #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_nx,
  input  logic [N-1:0] mask_nx,
  output logic         irq_nx,
  output logic         irq_q
);
  assign irq_nx = |(flags_nx & ~mask_nx);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_nx;
  end
endmodule

// File: rtl/fpx_status_ctrl.sv
module fpx_status_ctrl
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAG-1:0]  dp_flags,
  input  logic              dp_stk_fault,
  input  logic [TOP_W-1:0]  top_ptr,
  input  logic [COND_W-1:0] cond,
  input  logic              cw_wr,
  input  logic [WORD_W-1:0] cw_wdata,
  input  logic              sw_wr,
  input  logic [SWD_W-1:0]  sw_wdata,
  input  logic              cmd_init,
  input  logic              cmd_clex,
  output logic [WORD_W-1:0] cw_rd,
  output logic [WORD_W-1:0] sw_rd,
  output logic              irq
);
  flag_act_e         act;
  logic [NFLAG-1:0]  flags_nx;
  logic              sf_nx;
  logic [WORD_W-1:0] cw_nx;
  logic              irq_nx;
  logic [WORD_W-1:0] sw_nx;
  logic [WORD_W-1:0] sw_q;

  always_comb begin
    if (cmd_init)      act = ACT_INIT;
    else if (cmd_clex) act = ACT_CLEAR;
    else if (sw_wr)    act = ACT_LOAD;
    else               act = ACT_HOLD;
  end

  fpx_flag_bank #(.N(NFLAG)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .ld_flags  (sw_wdata[NFLAG-1:0]),
    .ld_sf     (sw_wdata[SF_BIT]),
    .raise     (dp_flags),
    .stk_fault (dp_stk_fault),
    .flags_nx  (flags_nx),
    .sf_nx     (sf_nx)
  );

  fpx_ctrl_reg #(.W(WORD_W), .INIT_VAL(CW_INIT)) u_cw (
    .clk   (clk),
    .rst   (rst),
    .init  (cmd_init),
    .wr    (cw_wr),
    .wdata (cw_wdata),
    .cw_nx (cw_nx),
    .cw_q  (cw_rd)
  );

  fpx_irq_gen #(.N(NFLAG)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .flags_nx (flags_nx),
    .mask_nx  (cw_nx[NFLAG-1:0]),
    .irq_nx   (irq_nx),
    .irq_q    (irq)
  );

  // Status word: 15 zero, 14 cond[3], 13:11 top, 10:8 cond[2:0], 7 irq, 6 stack fault, 5:0 flags
  assign sw_nx = {1'b0, cond[3], top_ptr, cond[2:0], irq_nx, sf_nx, flags_nx};

  always_ff @(posedge clk) begin
    if (rst) sw_q <= '0;
    else     sw_q <= sw_nx;
  end

  assign sw_rd = sw_q;
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk
  import fpx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NFLAG-1:0]  dp_flags,
  input logic              dp_stk_fault,
  input logic [TOP_W-1:0]  top_ptr,
  input logic              cw_wr,
  input logic [WORD_W-1:0] cw_wdata,
  input logic              sw_wr,
  input logic              cmd_init,
  input logic              cmd_clex,
  input logic [WORD_W-1:0] cw_rd,
  input logic [WORD_W-1:0] sw_rd,
  input logic              irq
);
  AST_INIT_VALUES: assert property (@(posedge clk) disable iff (rst)
    cmd_init |=> (cw_rd == CW_INIT && sw_rd[7:0] == 8'h00 && !irq)); // R5

  AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (rst)
    !cmd_init |=> ((sw_rd[NFLAG-1:0] & $past(dp_flags)) == $past(dp_flags))); // R2

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!cmd_init && !cmd_clex && !sw_wr) |=>
      ((sw_rd[NFLAG-1:0] & $past(sw_rd[NFLAG-1:0])) == $past(sw_rd[NFLAG-1:0]))); // R3

  AST_CLEX_RESULT: assert property (@(posedge clk) disable iff (rst)
    (cmd_clex && !cmd_init) |=>
      (sw_rd[SF_BIT] == $past(dp_stk_fault) &&
       sw_rd[NFLAG-1:0] == ($past(dp_flags) | {{(NFLAG-1){1'b0}}, $past(dp_stk_fault)}))); // R4

  AST_SF_IMPLIES_INV: assert property (@(posedge clk) disable iff (rst)
    sw_rd[SF_BIT] |-> sw_rd[0]); // R6

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq == |(sw_rd[NFLAG-1:0] & ~cw_rd[NFLAG-1:0])); // R7

  AST_IRQ_BIT: assert property (@(posedge clk) disable iff (rst)
    sw_rd[IRQ_BIT] == irq); // R7

  AST_CW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cw_wr && !cmd_init) |=> (cw_rd == $past(cw_wdata))); // R8

  AST_TOP_FIELD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (sw_rd[13:11] == $past(top_ptr) && !sw_rd[15])); // R10
endmodule

bind fpx_status_ctrl fpx_status_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .dp_flags     (dp_flags),
  .dp_stk_fault (dp_stk_fault),
  .top_ptr      (top_ptr),
  .cw_wr        (cw_wr),
  .cw_wdata     (cw_wdata),
  .sw_wr        (sw_wr),
  .cmd_init     (cmd_init),
  .cmd_clex     (cmd_clex),
  .cw_rd        (cw_rd),
  .sw_rd        (sw_rd),
  .irq          (irq)
);

// File: tb/sim_fpx_status_ctrl.sv
module sim_fpx_status_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  dp_flags = '0;
  logic        dp_stk_fault = 1'b0;
  logic [2:0]  top_ptr = '0;
  logic [3:0]  cond = '0;
  logic        cw_wr = 1'b0;
  logic [15:0] cw_wdata = '0;
  logic        sw_wr = 1'b0;
  logic [6:0]  sw_wdata = '0;
  logic        cmd_init = 1'b0;
  logic        cmd_clex = 1'b0;
  logic [15:0] cw_rd;
  logic [15:0] sw_rd;
  logic        irq;

  int n_run = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fpx_status_ctrl u0 (.*);

  typedef struct packed {
    logic        ini;
    logic        clx;
    logic        cww;
    logic [15:0] cwd;
    logic        sww;
    logic [6:0]  swd;
    logic [5:0]  dpf;
    logic        stf;
    logic [7:0]  esw;
    logic [15:0] ecw;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,16'h0000,1'b0,7'h00,6'h01,1'b0,8'h01,16'h037F,4'd2},  // R2 invalid, masked
    '{1'b0,1'b0,1'b0,16'h0000,1'b0,7'h00,6'h04,1'b0,8'h05,16'h037F,4'd3},  // R3 sticky
    '{1'b0,1'b0,1'b1,16'h037B,1'b0,7'h00,6'h00,1'b0,8'h85,16'h037B,4'd8},  // R8 unmask set flag
    '{1'b0,1'b1,1'b0,16'h0000,1'b0,7'h00,6'h00,1'b0,8'h00,16'h037B,4'd4},  // R4 clear
    '{1'b0,1'b0,1'b0,16'h0000,1'b0,7'h00,6'h04,1'b0,8'h84,16'h037B,4'd7},  // R7 unmasked raise
    '{1'b0,1'b1,1'b0,16'h0000,1'b0,7'h00,6'h10,1'b0,8'h10,16'h037B,4'd4},  // R4 clear + masked raise
    '{1'b0,1'b1,1'b0,16'h0000,1'b0,7'h00,6'h04,1'b0,8'h84,16'h037B,4'd4},  // R4 clear + unmasked raise
    '{1'b0,1'b0,1'b0,16'h0000,1'b0,7'h00,6'h00,1'b1,8'hC5,16'h037B,4'd6},  // R6 stack fault
    '{1'b1,1'b0,1'b0,16'h0000,1'b0,7'h00,6'h00,1'b0,8'h00,16'h037F,4'd5},  // R5 init
    '{1'b1,1'b0,1'b0,16'h0000,1'b0,7'h00,6'h3F,1'b0,8'h00,16'h037F,4'd5},  // R5 init beats raise
    '{1'b0,1'b0,1'b1,16'h0340,1'b0,7'h00,6'h00,1'b0,8'h00,16'h0340,4'd8},  // R8 unmask all, no flag
    '{1'b0,1'b0,1'b0,16'h0000,1'b0,7'h00,6'h20,1'b0,8'hA0,16'h0340,4'd2},  // R2 precision bit 5
    '{1'b0,1'b0,1'b0,16'h0000,1'b1,7'h00,6'h02,1'b0,8'h82,16'h0340,4'd9},  // R9 load zero OR raise
    '{1'b0,1'b0,1'b0,16'h0000,1'b1,7'h41,6'h00,1'b0,8'hC1,16'h0340,4'd9},  // R9 load fault+invalid
    '{1'b0,1'b0,1'b1,16'h037F,1'b0,7'h00,6'h00,1'b0,8'h41,16'h037F,4'd7},  // R7 mask all drops irq
    '{1'b0,1'b1,1'b0,16'h0000,1'b0,7'h00,6'h00,1'b0,8'h00,16'h037F,4'd4},  // R4 clears fault bit
    '{1'b1,1'b1,1'b1,16'h0000,1'b1,7'h7F,6'h3F,1'b1,8'h00,16'h037F,4'd5}   // R5 init beats all
  };

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    dp_flags = '0; dp_stk_fault = 1'b0; cw_wr = 1'b0; cw_wdata = '0;
    sw_wr = 1'b0; sw_wdata = '0; cmd_init = 1'b0; cmd_clex = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk16("R1 cw", cw_rd, 16'h037F);
    chk16("R1 sw", sw_rd, 16'h0000);
    chk16("R1 irq", {15'b0, irq}, 16'h0000);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      idle();
      cmd_init = TBL[k].ini; cmd_clex = TBL[k].clx;
      cw_wr = TBL[k].cww; cw_wdata = TBL[k].cwd;
      sw_wr = TBL[k].sww; sw_wdata = TBL[k].swd;
      dp_flags = TBL[k].dpf; dp_stk_fault = TBL[k].stf;
      @(negedge clk);
      chk16($sformatf("R%0d row%0d sw", TBL[k].rq, k), sw_rd, {8'h00, TBL[k].esw});
      chk16($sformatf("R%0d row%0d cw", TBL[k].rq, k), cw_rd, TBL[k].ecw);
      chk16($sformatf("R7 row%0d irq", k), {15'b0, irq}, {15'b0, TBL[k].esw[7]});
    end
    idle();

    // R10 neighbour fields merged after one edge
    top_ptr = 3'd5; cond = 4'b1011;
    @(negedge clk);
    chk16("R10 top/cond", sw_rd, 16'h6B00);
    top_ptr = 3'd2; cond = 4'b0100;
    @(negedge clk);
    chk16("R10 top/cond", sw_rd, 16'h1400);
    top_ptr = '0; cond = '0;

    // R3 sticky under idle, then R1 reset mid-run
    cw_wr = 1'b1; cw_wdata = 16'h0377;
    dp_flags = 6'h08;
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    chk16("R3 hold", sw_rd, 16'h0088);
    rst = 1'b1;
    @(negedge clk);
    chk16("R1 cw", cw_rd, 16'h037F);
    chk16("R1 sw", sw_rd, 16'h0000);
    chk16("R1 irq", {15'b0, irq}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule